// File: doc/BRIEF.md
# Codec Command and Status Register Front End

This block is the host-facing register pair of a serial audio codec link controller. Software writes a 32-bit command word that carries a 16-bit data value, a two-bit codec select and an 8-bit codec register address. The block keeps the command and raises a busy flag. It also presents a send request to the link side, and holds both until the link acknowledges that the command has gone out. A set top bit in the register address turns the command into a read request.

On the return path, the link hands over status frames through a one-cycle capture strobe. Each frame carries a 16-bit data value and the address of the register it answers. The block stores the frame in a status register that has a sticky valid flag and a new-data flag. A host read of the status register clears the new-data flag.

Software polls both registers with its own bounded retry count, so the block has no timeout logic. Host reads are combinational. Host writes and link events take effect at the next rising clock edge.

Top module: `codec_link_regs`

## Requirements
- R1: Command register readback layout: bits 15:0 hold the data value, bit 16 is the busy flag, bits 23:22 hold the codec select, bits 31:24 hold the register address, and bits 21:17 read as zero. The command register is at host offset 1.
- R2: A command write with select 00 (primary) or 01 (secondary), made while busy is clear, sets busy at the next edge. It also raises `link_req`, with the written address, select and data on the link outputs.
- R3: A `link_ack` while busy is set clears busy and `link_req` at the next edge and leaves the stored fields unchanged. A `link_ack` while busy is clear has no effect.
- R4: A command write made while busy is set is ignored, and no second request is made. This also holds when the write arrives in the same cycle as the `link_ack` that clears busy.
- R5: A command write with select 10 or 11 stores all fields but leaves busy clear, and `link_req` stays low.
- R6: `link_is_read` equals bit 7 of the stored register address (bit 31 of the command word).
- R7: A `stat_capture` strobe stores `stat_data` in status bits 15:0 and `stat_addr` in status bits 31:24, and sets the valid flag (bit 16) and the new flag (bit 17) at the next edge. Status bits 23:18 read as zero. The status register is at host offset 0.
- R8: A host read of the status register returns the value from before the clear. Afterwards, the new flag is clear and the valid flag stays set.
- R9: When a status read and a capture fall in the same cycle, the read returns the old value and the new flag stays set, with the newly captured frame stored.
- R10: After reset, both registers read zero and `link_req` is low.
- R11: Host offsets 2 and 3 read as zero, and writes to them change nothing.
- R12: Bit 16 and bits 21:17 of the command write data are ignored; the hardware alone owns the busy flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host write strobe |
| host_rd_en | input | 1 | Host read strobe |
| host_addr | input | 2 | Register offset (0 status, 1 command) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational) |
| link_req | output | 1 | Command waiting to be sent |
| link_addr | output | 8 | Codec register address of the pending command |
| link_codec | output | 2 | Codec select of the pending command |
| link_data | output | 16 | Data value of the pending command |
| link_is_read | output | 1 | Pending command is a read request |
| link_ack | input | 1 | Link reports the command has been sent |
| stat_capture | input | 1 | One-cycle strobe carrying a status frame |
| stat_addr | input | 8 | Register address echoed by the frame |
| stat_data | input | 16 | Codec data in the frame |

## Verification
Two pairs of events can land on the same edge: a host command write together with the link acknowledge, and a host status read together with a frame capture. The bench drives each pair in a single cycle. For the first pair, it expects the acknowledge to win and the write to be dropped, so the command reads back with busy clear and the old fields. For the second pair, it expects the read to return the previous frame, and a later read to show the new frame with the new flag still set.

// File: rtl/codec_regs_pkg.sv
package codec_regs_pkg;

  localparam int REG_W       = 32;
  localparam int CDATA_W     = 16;
  localparam int CADDR_W     = 8;
  localparam int CSEL_W      = 2;
  localparam int BUSY_BIT    = 16;
  localparam int NEW_BIT     = 17;
  localparam int SEL_LSB     = 22;
  localparam int ADDR_LSB    = 24;
  localparam int SEL_MSB     = SEL_LSB + CSEL_W - 1;
  localparam int ADDR_MSB    = ADDR_LSB + CADDR_W - 1;

  typedef struct packed {
    logic [CADDR_W-1:0] addr;
    logic [CSEL_W-1:0]  sel;
    logic [CDATA_W-1:0] data;
  } cmd_fields_t;

  typedef struct packed {
    logic [CADDR_W-1:0] addr;
    logic [CDATA_W-1:0] data;
  } stat_fields_t;

  // Select codes 00 and 01 name a real codec; 10 and 11 are never issued.
  function automatic logic sel_issuable(input logic [CSEL_W-1:0] sel);
    return sel[CSEL_W-1] == 1'b0;
  endfunction

  function automatic logic addr_is_read(input logic [CADDR_W-1:0] addr);
    return addr[CADDR_W-1];
  endfunction

  function automatic cmd_fields_t cmd_from_word(input logic [REG_W-1:0] w);
    cmd_fields_t f;
    f.addr = w[ADDR_MSB:ADDR_LSB];
    f.sel  = w[SEL_MSB:SEL_LSB];
    f.data = w[CDATA_W-1:0];
    return f;
  endfunction

  function automatic logic [REG_W-1:0] cmd_to_word(input cmd_fields_t f, input logic busy);
    logic [REG_W-1:0] w;
    w = '0;
    w[ADDR_MSB:ADDR_LSB] = f.addr;
    w[SEL_MSB:SEL_LSB]   = f.sel;
    w[BUSY_BIT]          = busy;
    w[CDATA_W-1:0]       = f.data;
    return w;
  endfunction

  function automatic logic [REG_W-1:0] stat_to_word(input stat_fields_t f,
                                                    input logic vld, input logic fresh);
    logic [REG_W-1:0] w;
    w = '0;
    w[ADDR_MSB:ADDR_LSB] = f.addr;
    w[NEW_BIT]           = fresh;
    w[BUSY_BIT]          = vld;
    w[CDATA_W-1:0]       = f.data;
    return w;
  endfunction

endpackage

// File: rtl/codec_host_decode.sv
module codec_host_decode
  import codec_regs_pkg::*;
#(
  parameter int HADDR_W  = 2,
  parameter int STAT_OFS = 0,
  parameter int CMD_OFS  = 1
) (
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [HADDR_W-1:0] addr,
  input  logic [REG_W-1:0]   cmd_word,
  input  logic [REG_W-1:0]   stat_word,
  output logic               wr_cmd,
  output logic               rd_stat,
  output logic [REG_W-1:0]   rdata
);

  logic hit_stat, hit_cmd;

  assign hit_stat = (addr == HADDR_W'(STAT_OFS));
  assign hit_cmd  = (addr == HADDR_W'(CMD_OFS));
  assign wr_cmd   = wr_en && hit_cmd;
  assign rd_stat  = rd_en && hit_stat;

  always_comb begin
    rdata = '0;
    if (hit_stat)     rdata = stat_word;
    else if (hit_cmd) rdata = cmd_word;
  end

endmodule

// File: rtl/codec_cmd_reg.sv
module codec_cmd_reg
  import codec_regs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_cmd,
  input  logic [REG_W-1:0]   wdata,
  input  logic               link_ack,
  output logic [REG_W-1:0]   cmd_word,
  output logic               link_req,
  output cmd_fields_t        link_fields,
  output logic               link_is_read
);

  cmd_fields_t fields_q, fields_in;
  logic        busy_q;

  // named events for the checks below
  logic load_accept, load_issue, busy_drop, write_blocked;

  assign fields_in     = cmd_from_word(wdata);
  assign load_accept   = wr_cmd && !busy_q;
  assign load_issue    = load_accept && sel_issuable(fields_in.sel);
  assign busy_drop     = busy_q && link_ack;
  assign write_blocked = wr_cmd && busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields_q <= '0;
      busy_q   <= 1'b0;
    end else if (load_accept) begin
      fields_q <= fields_in;
      busy_q   <= load_issue;
    end else if (busy_drop) begin
      busy_q   <= 1'b0;
    end
  end

  assign cmd_word     = cmd_to_word(fields_q, busy_q);
  assign link_req     = busy_q;
  assign link_fields  = fields_q;
  assign link_is_read = addr_is_read(fields_q.addr);

  assert_issue_raises_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_issue |=> link_req && link_fields.addr == $past(wdata[ADDR_MSB:ADDR_LSB])
                   && link_fields.data == $past(wdata[CDATA_W-1:0]));

  assert_ack_clears_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_drop |=> !link_req);

  assert_busy_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    write_blocked |=> $stable(cmd_word[REG_W-1:BUSY_BIT+1]) && $stable(cmd_word[CDATA_W-1:0]));

  assert_reserved_not_issued_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_accept && !sel_issuable(fields_in.sel) |=> !link_req);

  assert_req_has_legal_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    link_req |-> sel_issuable(link_fields.sel));

endmodule

// File: rtl/codec_stat_reg.sv
module codec_stat_reg
  import codec_regs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  stat_fields_t       frame,
  input  logic               rd_stat,
  output logic [REG_W-1:0]   stat_word
);

  stat_fields_t frame_q;
  logic         vld_q, new_q;
  logic         frame_take, new_clear;

  assign frame_take = capture;
  assign new_clear  = rd_stat && !capture;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      vld_q   <= 1'b0;
      new_q   <= 1'b0;
    end else begin
      if (frame_take) begin
        frame_q <= frame;
        vld_q   <= 1'b1;
        new_q   <= 1'b1;
      end else if (new_clear) begin
        new_q   <= 1'b0;
      end
    end
  end

  assign stat_word = stat_to_word(frame_q, vld_q, new_q);

  assert_capture_sets_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_take |=> stat_word[BUSY_BIT] && stat_word[NEW_BIT]
                   && stat_word[CDATA_W-1:0] == $past(frame.data));

  assert_read_clears_new_R8: assert property (@(posedge clk) disable iff (!rst_n)
    new_clear |=> !stat_word[NEW_BIT] && stat_word[BUSY_BIT] == $past(stat_word[BUSY_BIT]));

  assert_collision_keeps_new_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat && capture |=> stat_word[NEW_BIT]);

endmodule

// File: rtl/codec_link_regs.sv
module codec_link_regs
  import codec_regs_pkg::*;
#(
  parameter int HADDR_W  = 2,
  parameter int STAT_OFS = 0,
  parameter int CMD_OFS  = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr_en,
  input  logic               host_rd_en,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic [REG_W-1:0]   host_wdata,
  output logic [REG_W-1:0]   host_rdata,
  output logic               link_req,
  output logic [CADDR_W-1:0] link_addr,
  output logic [CSEL_W-1:0]  link_codec,
  output logic [CDATA_W-1:0] link_data,
  output logic               link_is_read,
  input  logic               link_ack,
  input  logic               stat_capture,
  input  logic [CADDR_W-1:0] stat_addr,
  input  logic [CDATA_W-1:0] stat_data
);

  logic         wr_cmd, rd_stat;
  logic [REG_W-1:0] cmd_word, stat_word;
  cmd_fields_t  link_fields;
  stat_fields_t frame;

  assign frame.addr = stat_addr;
  assign frame.data = stat_data;

  codec_host_decode #(
    .HADDR_W (HADDR_W),
    .STAT_OFS(STAT_OFS),
    .CMD_OFS (CMD_OFS)
  ) u_dec (
    .wr_en    (host_wr_en),
    .rd_en    (host_rd_en),
    .addr     (host_addr),
    .cmd_word (cmd_word),
    .stat_word(stat_word),
    .wr_cmd   (wr_cmd),
    .rd_stat  (rd_stat),
    .rdata    (host_rdata)
  );

  codec_cmd_reg u_cmd (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_cmd      (wr_cmd),
    .wdata       (host_wdata),
    .link_ack    (link_ack),
    .cmd_word    (cmd_word),
    .link_req    (link_req),
    .link_fields (link_fields),
    .link_is_read(link_is_read)
  );

  codec_stat_reg u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (stat_capture),
    .frame    (frame),
    .rd_stat  (rd_stat),
    .stat_word(stat_word)
  );

  assign link_addr  = link_fields.addr;
  assign link_codec = link_fields.sel;
  assign link_data  = link_fields.data;

  assert_read_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    link_is_read == host_rdata[31] || host_addr != HADDR_W'(CMD_OFS));

endmodule

// File: tb/sim_codec_link_regs.sv
module sim_codec_link_regs;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr_en = 1'b0, host_rd_en = 1'b0;
  logic [1:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        link_req, link_is_read;
  logic [7:0]  link_addr;
  logic [1:0]  link_codec;
  logic [15:0] link_data;
  logic        link_ack = 1'b0, stat_capture = 1'b0;
  logic [7:0]  stat_addr = '0;
  logic [15:0] stat_data = '0;

  int tests = 0, fails = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } rd_item_t;
  rd_item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  codec_link_regs u0 (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(host_wr_en), .host_rd_en(host_rd_en), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .link_req(link_req), .link_addr(link_addr), .link_codec(link_codec),
    .link_data(link_data), .link_is_read(link_is_read), .link_ack(link_ack),
    .stat_capture(stat_capture), .stat_addr(stat_addr), .stat_data(stat_data)
  );

  // expected command word: addr in 31:24, select in 23:22, busy in 16, data in 15:0
  function automatic logic [31:0] exp_cmd(input logic [7:0] a, input logic [1:0] s,
                                          input logic b, input logic [15:0] d);
    return {a, s, 5'b0, b, d};
  endfunction

  // expected status word: addr in 31:24, new in 17, valid in 16, data in 15:0
  function automatic logic [31:0] exp_stat(input logic [7:0] a, input logic n,
                                           input logic v, input logic [15:0] d);
    return {a, 6'b0, n, v, d};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compares every host read against the scoreboard head
  always @(negedge clk) begin
    if (host_rd_en) begin
      if (sb_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL scoreboard: read with no expectation, got %h expected none", host_rdata);
      end else begin
        rd_item_t it;
        it = sb_q.pop_front();
        check(it.tag, host_rdata, it.exp);
      end
    end
  end

  task automatic slot();
    @(posedge clk); #1;
    host_wr_en = 1'b0; host_rd_en = 1'b0; link_ack = 1'b0; stat_capture = 1'b0;
  endtask

  task automatic host_write(input logic [1:0] a, input logic [31:0] d);
    host_wr_en = 1'b1; host_addr = a; host_wdata = d;
    slot();
  endtask

  task automatic host_read(input logic [1:0] a, input logic [31:0] exp, input string tag);
    rd_item_t it;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    host_rd_en = 1'b1; host_addr = a;
    slot();
  endtask

  task automatic pulse_ack();
    link_ack = 1'b1;
    slot();
  endtask

  task automatic capture(input logic [7:0] a, input logic [15:0] d);
    stat_capture = 1'b1; stat_addr = a; stat_data = d;
    slot();
  endtask

  task automatic check_link(input string tag, input logic req, input logic [7:0] a,
                            input logic [1:0] s, input logic [15:0] d, input logic rd);
    @(negedge clk);
    check({tag, " link_req"}, {31'b0, link_req}, {31'b0, req});
    if (req) begin
      check({tag, " link_fields"}, {link_addr, 6'b0, link_codec, link_data},
            {a, 6'b0, s, d});
      check({tag, " link_is_read R6"}, {31'b0, link_is_read}, {31'b0, rd});
    end
    @(posedge clk); #1;
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    slot();

    // R10 reset state
    host_read(2'd0, 32'h0, "R10 status after reset");
    host_read(2'd1, 32'h0, "R10 command after reset");
    check_link("R10", 1'b0, 8'h0, 2'h0, 16'h0, 1'b0);

    // R1 R2 R12: write with busy and reserved bits forced to one
    host_write(2'd1, 32'h123FABCD);
    host_read(2'd1, exp_cmd(8'h12, 2'b00, 1'b1, 16'hABCD), "R1 R12 command readback busy");
    check_link("R2 issue primary", 1'b1, 8'h12, 2'b00, 16'hABCD, 1'b0);

    // R4 write while busy is ignored
    host_write(2'd1, 32'h55405555);
    host_read(2'd1, exp_cmd(8'h12, 2'b00, 1'b1, 16'hABCD), "R4 busy write ignored");
    check_link("R4 no second request", 1'b1, 8'h12, 2'b00, 16'hABCD, 1'b0);

    // R3 ack clears busy, idle ack ignored
    pulse_ack();
    host_read(2'd1, exp_cmd(8'h12, 2'b00, 1'b0, 16'hABCD), "R3 ack clears busy");
    check_link("R3 request dropped", 1'b0, 8'h0, 2'h0, 16'h0, 1'b0);
    pulse_ack();
    host_read(2'd1, exp_cmd(8'h12, 2'b00, 1'b0, 16'hABCD), "R3 idle ack no effect");

    // R6 read request to secondary codec
    host_write(2'd1, 32'h85400000);
    host_read(2'd1, exp_cmd(8'h85, 2'b01, 1'b1, 16'h0000), "R2 secondary readback");
    check_link("R6 read request", 1'b1, 8'h85, 2'b01, 16'h0000, 1'b1);

    // R4 collision: ack and write in the same cycle
    link_ack = 1'b1;
    host_write(2'd1, 32'h22003333);
    host_read(2'd1, exp_cmd(8'h85, 2'b01, 1'b0, 16'h0000), "R4 write with ack dropped");
    check_link("R4 collision no request", 1'b0, 8'h0, 2'h0, 16'h0, 1'b0);

    // R5 reserved selects
    host_write(2'd1, 32'h33801111);
    host_read(2'd1, exp_cmd(8'h33, 2'b10, 1'b0, 16'h1111), "R5 select 10 stored idle");
    check_link("R5 select 10 not issued", 1'b0, 8'h0, 2'h0, 16'h0, 1'b0);
    host_write(2'd1, 32'h44C02222);
    host_read(2'd1, exp_cmd(8'h44, 2'b11, 1'b0, 16'h2222), "R5 select 11 stored idle");
    check_link("R5 select 11 not issued", 1'b0, 8'h0, 2'h0, 16'h0, 1'b0);

    // R11 unmapped offsets
    host_write(2'd2, 32'h01000005);
    host_write(2'd3, 32'h01000006);
    host_read(2'd1, exp_cmd(8'h44, 2'b11, 1'b0, 16'h2222), "R11 unmapped write ignored");
    check_link("R11 no request", 1'b0, 8'h0, 2'h0, 16'h0, 1'b0);
    host_read(2'd2, 32'h0, "R11 offset 2 reads zero");
    host_read(2'd3, 32'h0, "R11 offset 3 reads zero");

    // R7 R8 capture then read-to-clear
    capture(8'h7C, 16'h0F0F);
    host_read(2'd0, exp_stat(8'h7C, 1'b1, 1'b1, 16'h0F0F), "R7 capture sets valid and new");
    host_read(2'd0, exp_stat(8'h7C, 1'b0, 1'b1, 16'h0F0F), "R8 read clears new keeps valid");

    // R9 read and capture together
    stat_capture = 1'b1; stat_addr = 8'h02; stat_data = 16'h1234;
    host_read(2'd0, exp_stat(8'h7C, 1'b0, 1'b1, 16'h0F0F), "R9 collision read old value");
    host_read(2'd0, exp_stat(8'h02, 1'b1, 1'b1, 16'h1234), "R9 new kept after collision");
    host_read(2'd0, exp_stat(8'h02, 1'b0, 1'b1, 16'h1234), "R8 second read clears new");

    // R2 issue again after idle, primary write request
    host_write(2'd1, 32'h0A00BEEF);
    host_read(2'd1, exp_cmd(8'h0A, 2'b00, 1'b1, 16'hBEEF), "R2 reissue after idle");
    check_link("R2 reissue link", 1'b1, 8'h0A, 2'b00, 16'hBEEF, 1'b0);

    repeat (2) slot();
    if (sb_q.size() != 0) begin
      tests++; fails++;
      $display("FAIL scoreboard: got %0d pending expected 0", sb_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule